// File: doc/BRIEF.md
# Converter Serial Port With Abort

This block is the device side of a four-wire serial port on a data converter. It runs the converter's cycle of converting and sleeping. It reports end-of-conversion (EOC) on the serial output. In one transfer it shifts out a 24-bit result word and shifts in a configuration command of up to two bytes. A cycle counter stands in for the conversion. When that counter expires, the block captures a parallel result (a sign bit and magnitude bits) into its output shift register and goes to sleep on its own.

The serial pins are asynchronous to the system clock. Chip select, serial clock and serial data in each pass through two flip-flops, and edges are detected on the synchronised copies.

A transfer starts on the first serial-clock rise seen while chip select is low and the block is asleep. It ends in one of two ways:
- on the 24th falling edge, or
- early, when chip select rises.

Either end starts a new conversion. How much of the shifted-in command is kept depends on how many falling edges came before chip select rose. The kept settings apply to the next conversion.

Top module: `conv_serial_port`

## Requirements
- R1: `sdo_oe_o` is 0 whenever the synchronised chip select is high and 1 whenever it is low. The enable follows `csb_i` two system clocks late.
- R2: SDO shows EOC. The value is 1 for the whole conversion and 0 in the sleep state before the first serial-clock rise.
- R3: A conversion lasts exactly CONV_CYC system clocks. At its end the block loads `{0, 0, res_sign_i, res_data_i}` into the output frame and sleeps. Serial-clock edges during a conversion change nothing.
- R4: A transfer begins on the first synchronised SCK rise while chip select is low, the block is asleep and external-clock mode is set. SDI is sampled on every rise from that one on. The frame is sent MSB first: bit 23 is EOC (0), bit 22 is 0, bit 21 is the sign, and bits 20..0 are the result magnitude MSB first. The next bit appears after each SCK fall.
- R5: The 24th falling SCK edge of a transfer starts a new conversion, and SDO returns to 1.
- R6: A chip-select rise during a transfer aborts it and starts a new conversion at once, with SDO at 1.
- R7: If the abort comes after fewer than 8 falling edges, `chan_o` and `cfg_o` keep their old values.
- R8: If the abort comes after 8 to 15 falling edges, only `chan_o` is loaded. It takes the first 8 SDI bits, the first bit sampled landing in bit 7. `cfg_o` is unchanged.
- R9: After 16 or more falling edges, whether by abort or by a full 24-bit transfer, both registers are loaded. `cfg_o` takes SDI bits 9 to 16, the ninth bit sampled landing in bit 7.
- R10: A chip-select fall while SCK is high clears `ext_clk_o`. While it is clear, SCK rises do not start a transfer. A chip-select fall while SCK is low sets `ext_clk_o` again.
- R11: After reset the block is converting, `chan_o` and `cfg_o` are 0, and `ext_clk_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csb_i | input | 1 | Chip select, active low, asynchronous |
| sck_i | input | 1 | Serial clock from the host, asynchronous |
| sdi_i | input | 1 | Serial command data from the host |
| res_sign_i | input | 1 | Sign of the result from the conversion model |
| res_data_i | input | RES_W (21) | Result magnitude from the conversion model |
| sdo_o | output | 1 | Serial output data (EOC, then the frame) |
| sdo_oe_o | output | 1 | Output enable for SDO; 0 means high impedance |
| chan_o | output | CMD_W (8) | Active channel command byte |
| cfg_o | output | CMD_W (8) | Active configuration command byte |
| ext_clk_o | output | 1 | 1 while external serial-clock mode is selected |

## Verification
The hardest states to reach are the abort boundaries. Chip select must rise after exactly 7, 8, 12 and 16 falling edges, and each rise must land after the synchronised fall has been counted. The stimulus therefore counts bits itself and holds every SCK phase for several system clocks before raising chip select. It then checks which command bytes survived. A second hard case is clock-mode selection, which needs chip select to fall while SCK is held high during sleep. After that, the stimulus shows that further SCK activity is ignored before it restores external mode.

// File: rtl/conv_port_pkg.sv
package conv_port_pkg;

  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_XFER  = 2'd2
  } port_state_t;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_CHAN = 2'd1,
    LD_BOTH = 2'd2
  } load_sel_t;

endpackage

// File: rtl/cp_sync_edge.sv
module cp_sync_edge #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      chain_q[0] <= in_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;

endmodule

// File: rtl/cp_conv_timer.sv
module cp_conv_timer #(
  parameter int CYC = 120
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic done_o
);

  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (start_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == LAST) run_q <= 1'b0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = run_q && (cnt_q == LAST);

endmodule

// File: rtl/cp_frame_shift.sv
module cp_frame_shift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  output logic         msb_o
);

  logic [W-1:0] frame_q;

  always_ff @(posedge clk) begin
    if (rst)          frame_q <= '0;
    else if (load_i)  frame_q <= load_val_i;
    else if (shift_i) frame_q <= {frame_q[W-2:0], 1'b0};
  end

  assign msb_o = frame_q[W-1];

endmodule

// File: rtl/cp_cmd_capture.sv
module cp_cmd_capture
  import conv_port_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             bit_i,
  input  load_sel_t        commit_i,
  output logic [CMD_W-1:0] chan_o,
  output logic [CMD_W-1:0] cfg_o
);

  localparam int NWORD = 2;

  logic [CMD_W-1:0] word_w [NWORD];

  for (genvar g = 0; g < NWORD; g++) begin : g_word
    localparam logic [IDX_W-1:0] LO = IDX_W'(g * CMD_W);
    localparam logic [IDX_W-1:0] HI = IDX_W'((g + 1) * CMD_W);
    logic [CMD_W-1:0] hold_q;
    always_ff @(posedge clk) begin
      if (rst)
        hold_q <= '0;
      else if (take_i && idx_i >= LO && idx_i < HI)
        hold_q <= {hold_q[CMD_W-2:0], bit_i};
    end
    assign word_w[g] = hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_o <= '0;
      cfg_o  <= '0;
    end else begin
      case (commit_i)
        LD_CHAN: chan_o <= word_w[0];
        LD_BOTH: begin
          chan_o <= word_w[0];
          cfg_o  <= word_w[1];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/conv_serial_port.sv
module conv_serial_port
  import conv_port_pkg::*;
#(
  parameter int RES_W       = 21,
  parameter int CMD_W       = 8,
  parameter int CONV_CYC    = 120,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             csb_i,
  input  logic             sck_i,
  input  logic             sdi_i,
  input  logic             res_sign_i,
  input  logic [RES_W-1:0] res_data_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [CMD_W-1:0] chan_o,
  output logic [CMD_W-1:0] cfg_o,
  output logic             ext_clk_o
);

  localparam int FRAME_W = RES_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CHAN_AT   = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] BOTH_AT   = CNT_W'(2 * CMD_W);
  localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] MAX_RISE  = CNT_W'(FRAME_W);

  // bit 0: chip select, bit 1: serial clock, bit 2: serial data
  logic [2:0] pin_lvl, pin_rise, pin_fall;

  cp_sync_edge #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)
  ) u_sync (
    .clk(clk), .rst(rst),
    .in_i({sdi_i, sck_i, csb_i}),
    .lvl_o(pin_lvl), .rise_o(pin_rise), .fall_o(pin_fall)
  );

  logic cs_lvl, cs_rise, cs_fall, sck_lvl, sck_rise, sck_fall, sdi_lvl;
  assign cs_lvl   = pin_lvl[0];
  assign cs_rise  = pin_rise[0];
  assign cs_fall  = pin_fall[0];
  assign sck_lvl  = pin_lvl[1];
  assign sck_rise = pin_rise[1];
  assign sck_fall = pin_fall[1];
  assign sdi_lvl  = pin_lvl[2];

  port_state_t      state_q, state_d;
  logic             ext_q;
  logic [CNT_W-1:0] rise_cnt_q, rise_cnt_d;
  logic [CNT_W-1:0] fall_cnt_q, fall_cnt_d;
  logic             conv_start, frame_load, frame_shift, bit_take;
  logic [CNT_W-1:0] bit_idx;
  load_sel_t        commit_sel;
  logic             tmr_done;
  logic             frame_msb;

  always_comb begin
    state_d     = state_q;
    rise_cnt_d  = rise_cnt_q;
    fall_cnt_d  = fall_cnt_q;
    conv_start  = 1'b0;
    frame_load  = 1'b0;
    frame_shift = 1'b0;
    bit_take    = 1'b0;
    commit_sel  = LD_NONE;
    case (state_q)
      ST_CONV: begin
        if (tmr_done) begin
          state_d    = ST_SLEEP;
          frame_load = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (sck_rise && !cs_lvl && ext_q) begin
          state_d    = ST_XFER;
          bit_take   = 1'b1;
          rise_cnt_d = CNT_W'(1);
          fall_cnt_d = '0;
        end
      end
      ST_XFER: begin
        if (cs_rise) begin
          state_d    = ST_CONV;
          conv_start = 1'b1;
          if (fall_cnt_q >= BOTH_AT)      commit_sel = LD_BOTH;
          else if (fall_cnt_q >= CHAN_AT) commit_sel = LD_CHAN;
        end else if (sck_fall) begin
          fall_cnt_d = fall_cnt_q + 1'b1;
          if (fall_cnt_q == LAST_FALL) begin
            state_d    = ST_CONV;
            conv_start = 1'b1;
            commit_sel = LD_BOTH;
          end else begin
            frame_shift = 1'b1;
          end
        end else if (sck_rise) begin
          bit_take = 1'b1;
          if (rise_cnt_q < MAX_RISE) rise_cnt_d = rise_cnt_q + 1'b1;
        end
      end
      default: state_d = ST_CONV;
    endcase
  end

  assign bit_idx = (state_q == ST_SLEEP) ? '0 : rise_cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_CONV;
      ext_q      <= 1'b1;
      rise_cnt_q <= '0;
      fall_cnt_q <= '0;
    end else begin
      state_q    <= state_d;
      rise_cnt_q <= rise_cnt_d;
      fall_cnt_q <= fall_cnt_d;
      if (cs_fall) ext_q <= ~sck_lvl;
    end
  end

  cp_conv_timer #(.CYC(CONV_CYC)) u_timer (
    .clk(clk), .rst(rst), .start_i(conv_start), .done_o(tmr_done)
  );

  cp_frame_shift #(.W(FRAME_W)) u_frame (
    .clk(clk), .rst(rst),
    .load_i(frame_load),
    .load_val_i({2'b00, res_sign_i, res_data_i}),
    .shift_i(frame_shift),
    .msb_o(frame_msb)
  );

  cp_cmd_capture #(.CMD_W(CMD_W), .IDX_W(CNT_W)) u_cmd (
    .clk(clk), .rst(rst),
    .take_i(bit_take), .idx_i(bit_idx), .bit_i(sdi_lvl),
    .commit_i(commit_sel),
    .chan_o(chan_o), .cfg_o(cfg_o)
  );

  assign sdo_o     = (state_q == ST_CONV) ? 1'b1 : frame_msb;
  assign sdo_oe_o  = ~cs_lvl;
  assign ext_clk_o = ext_q;

endmodule

// File: rtl/conv_serial_port_chk.sv
module conv_serial_port_chk
  import conv_port_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             csb_i,
  input logic             sdo_o,
  input logic             sdo_oe_o,
  input logic [CMD_W-1:0] chan_o,
  input logic [CMD_W-1:0] cfg_o,
  input logic             ext_q,
  input logic             tmr_done,
  input port_state_t      state_q,
  input logic [CNT_W-1:0] fall_cnt_q
);

  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)                warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 1'b1;
  end

  // R1: output enable tracks chip select two clocks late
  assert_hiz_follows_cs_R1: assert property (@(posedge clk) disable iff (rst)
    (warm_q >= 2'd2) |-> (sdo_oe_o == !$past(csb_i, 2)));

  // R2: asleep means EOC low on the output
  assert_eoc_low_asleep_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP) |-> !sdo_o);

  // R3: timer expiry only in conversion, and conversion holds until expiry
  assert_done_in_conv_R3: assert property (@(posedge clk) disable iff (rst)
    tmr_done |-> (state_q == ST_CONV));

  assert_conv_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV && !tmr_done) |=> (state_q == ST_CONV));

  // R7: channel register only changes as a transfer closes
  assert_chan_from_xfer_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(chan_o) |-> ($past(state_q) == ST_XFER));

  // R9: configuration changes only once enough falling edges were counted
  assert_cfg_late_R9: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_o) |-> ($past(fall_cnt_q) >= CNT_W'(2 * CMD_W - 1)));

  // R10: internal-clock mode never starts a transfer
  assert_no_xfer_internal_R10: assert property (@(posedge clk) disable iff (rst)
    (!ext_q && state_q == ST_SLEEP) |=> (state_q != ST_XFER));

endmodule

bind conv_serial_port conv_serial_port_chk #(.CMD_W(CMD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .csb_i(csb_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
  .chan_o(chan_o), .cfg_o(cfg_o), .ext_q(ext_q), .tmr_done(tmr_done),
  .state_q(state_q), .fall_cnt_q(fall_cnt_q)
);

// File: tb/sim_conv_serial_port.sv
`timescale 1ns/1ps
module sim_conv_serial_port;

  localparam int RES_W    = 21;
  localparam int CMD_W    = 8;
  localparam int CONV_CYC = 120;
  localparam int FRAME_W  = RES_W + 3;
  localparam int HALF     = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic csb = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic res_sign = 1'b0;
  logic [RES_W-1:0] res_data = '0;
  logic sdo, sdo_oe, ext_clk;
  logic [CMD_W-1:0] chan, cfg;

  always #2 clk = ~clk;

  conv_serial_port #(.RES_W(RES_W), .CMD_W(CMD_W), .CONV_CYC(CONV_CYC)) u0 (
    .clk(clk), .rst(rst), .csb_i(csb), .sck_i(sck), .sdi_i(sdi),
    .res_sign_i(res_sign), .res_data_i(res_data),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .chan_o(chan), .cfg_o(cfg), .ext_clk_o(ext_clk)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mst;              // 0 converting, 1 asleep, 2 transferring
  int mcnt, mrise, mfall;
  logic [FRAME_W-1:0] mframe;
  logic [CMD_W-1:0] mchan, mcfg, mb0, mb1;
  bit mext;
  bit hcs[$], hsck[$], hsdi[$];   // newest first: sample of last edge, one before, two before

  function automatic void model_reset();
    mst = 0; mcnt = 0; mrise = 0; mfall = 0; mframe = '0;
    mchan = '0; mcfg = '0; mb0 = '0; mb1 = '0; mext = 1'b1;
    hcs = '{1, 1, 1}; hsck = '{0, 0, 0}; hsdi = '{0, 0, 0};
  endfunction

  function automatic void model_take(input int idx, input bit b);
    if (idx < CMD_W)          mb0 = {mb0[CMD_W-2:0], b};
    else if (idx < 2 * CMD_W) mb1 = {mb1[CMD_W-2:0], b};
  endfunction

  initial model_reset();

  always @(posedge clk) begin
    if (rst) begin
      model_reset();
    end else begin
      bit cl, crise, cfall, sr, sf, sd, ext_old;
      cl = hcs[1]; crise = hcs[1] && !hcs[2]; cfall = !hcs[1] && hcs[2];
      sr = hsck[1] && !hsck[2]; sf = !hsck[1] && hsck[2]; sd = hsdi[1];
      ext_old = mext;
      if (cfall) mext = !hsck[1];
      case (mst)
        0: if (mcnt == CONV_CYC - 1) begin
             mst = 1; mframe = {2'b00, res_sign, res_data};
           end else mcnt++;
        1: if (sr && !cl && ext_old) begin
             mst = 2; mrise = 1; mfall = 0; model_take(0, sd);
           end
        default: begin
          if (crise) begin
            if (mfall >= 2 * CMD_W) begin mchan = mb0; mcfg = mb1; end
            else if (mfall >= CMD_W) mchan = mb0;
            mst = 0; mcnt = 0;
          end else if (sf) begin
            if (mfall == FRAME_W - 1) begin
              mchan = mb0; mcfg = mb1; mst = 0; mcnt = 0;
            end else mframe = mframe << 1;
            mfall++;
          end else if (sr) begin
            model_take(mrise, sd);
            mrise++;
          end
        end
      endcase
      void'(hcs.pop_back()); hcs.push_front(csb);
      void'(hsck.pop_back()); hsck.push_front(sck);
      void'(hsdi.pop_back()); hsdi.push_front(sdi);
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(sdo_oe == !hcs[1], "R1", "sdo_oe model", sdo_oe, !hcs[1]);
      check(sdo == ((mst == 0) ? 1'b1 : mframe[FRAME_W-1]), "R2", "sdo model",
            sdo, (mst == 0) ? 1'b1 : mframe[FRAME_W-1]);
      check(chan == mchan, "R8", "chan model", chan, mchan);
      check(cfg == mcfg, "R9", "cfg model", cfg, mcfg);
      check(ext_clk == mext, "R10", "ext model", ext_clk, mext);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_eoc(input string req);
    int waited;
    csb = 1'b0;
    waited = 0;
    tick(HALF);
    while (sdo !== 1'b0 && waited < 4 * CONV_CYC) begin
      tick(1);
      waited++;
    end
    check(sdo === 1'b0, req, "conversion ends with EOC low", sdo, 0);
  endtask

  // shifts nb bits (each with rise and fall); returns bits read before each rise
  task automatic xfer(input logic [2*CMD_W-1:0] cmd, input int nb,
                      output logic [FRAME_W-1:0] got);
    got = '0;
    for (int i = 0; i < nb; i++) begin
      sdi = (i < 2 * CMD_W) ? cmd[2*CMD_W-1-i] : 1'b0;
      tick(HALF);
      got[FRAME_W-1-i] = sdo;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
    tick(HALF);
  endtask

  task automatic abort_after(input logic [2*CMD_W-1:0] cmd, input int nb,
                             input logic [FRAME_W-1:0] exp_frame, input string req);
    logic [FRAME_W-1:0] got;
    logic [FRAME_W-1:0] mask;
    xfer(cmd, nb, got);
    mask = ~({FRAME_W{1'b1}} >> nb);
    check((got & mask) == (exp_frame & mask), "R4", "partial frame bits", got & mask, exp_frame & mask);
    csb = 1'b1;
    tick(HALF);
    csb = 1'b0;
    tick(HALF);
    check(sdo == 1'b1, req, "EOC high after abort (R6)", sdo, 1);
  endtask

  initial begin
    logic [FRAME_W-1:0] got, exp_f;
    res_sign = 1'b1;
    res_data = 21'h15A3C7;
    tick(5);
    rst = 1'b0;
    tick(1);
    check(sdo_oe == 1'b0, "R11", "oe after reset", sdo_oe, 0);
    check(chan == '0, "R11", "chan after reset", chan, 0);
    check(cfg == '0, "R11", "cfg after reset", cfg, 0);
    check(ext_clk == 1'b1, "R11", "ext after reset", ext_clk, 1);

    csb = 1'b0;
    tick(HALF);
    check(sdo_oe == 1'b1, "R1", "oe with CS low", sdo_oe, 1);
    check(sdo == 1'b1, "R2", "EOC high while converting", sdo, 1);
    wait_eoc("R3");

    // full transfer
    exp_f = {2'b00, res_sign, res_data};
    xfer(16'hA53C, FRAME_W, got);
    check(got == exp_f, "R4", "full frame", got, exp_f);
    check(sdo == 1'b1, "R5", "EOC high after 24th fall", sdo, 1);
    check(chan == 8'hA5, "R9", "chan after full", chan, 8'hA5);
    check(cfg == 8'h3C, "R9", "cfg after full", cfg, 8'h3C);

    // SCK activity during conversion is ignored (R3)
    res_sign = 1'b0;
    res_data = 21'h00F0F1;
    for (int i = 0; i < 4; i++) begin
      sdi = i[0];
      sck = 1'b1; tick(HALF);
      sck = 1'b0; tick(HALF);
    end
    check(chan == 8'hA5, "R3", "chan after SCK in conversion", chan, 8'hA5);
    wait_eoc("R3");

    exp_f = {2'b00, res_sign, res_data};
    abort_after(16'h9E71, 5, exp_f, "R6");
    check(chan == 8'hA5, "R7", "chan after 5-fall abort", chan, 8'hA5);
    check(cfg == 8'h3C, "R7", "cfg after 5-fall abort", cfg, 8'h3C);

    wait_eoc("R3");
    abort_after(16'h9E71, 8, exp_f, "R6");
    check(chan == 8'h9E, "R8", "chan after 8-fall abort", chan, 8'h9E);
    check(cfg == 8'h3C, "R8", "cfg after 8-fall abort", cfg, 8'h3C);

    res_sign = 1'b1;
    res_data = 21'h1FFFFF;
    wait_eoc("R3");
    exp_f = {2'b00, res_sign, res_data};
    abort_after(16'hC1FF, 12, exp_f, "R6");
    check(chan == 8'hC1, "R8", "chan after 12-fall abort", chan, 8'hC1);
    check(cfg == 8'h3C, "R8", "cfg after 12-fall abort", cfg, 8'h3C);

    wait_eoc("R3");
    abort_after(16'hB742, 16, exp_f, "R6");
    check(chan == 8'hB7, "R9", "chan after 16-fall abort", chan, 8'hB7);
    check(cfg == 8'h42, "R9", "cfg after 16-fall abort", cfg, 8'h42);

    wait_eoc("R3");
    abort_after(16'h8000, 7, exp_f, "R6");
    check(chan == 8'hB7, "R7", "chan after 7-fall abort", chan, 8'hB7);
    check(cfg == 8'h42, "R7", "cfg after 7-fall abort", cfg, 8'h42);

    // clock mode selection (R10)
    res_sign = 1'b0;
    res_data = 21'h0A5A5A;
    wait_eoc("R3");
    csb = 1'b1; tick(HALF);
    sck = 1'b1; tick(HALF);
    csb = 1'b0; tick(HALF);
    check(ext_clk == 1'b0, "R10", "internal mode on CS fall with SCK high", ext_clk, 0);
    for (int i = 0; i < 3; i++) begin
      sck = 1'b0; tick(HALF);
      sck = 1'b1; tick(HALF);
    end
    sck = 1'b0; tick(HALF);
    check(sdo == 1'b0, "R10", "still asleep in internal mode", sdo, 0);
    csb = 1'b1; tick(HALF);
    check(chan == 8'hB7, "R10", "chan untouched in internal mode", chan, 8'hB7);
    csb = 1'b0; tick(HALF);
    check(ext_clk == 1'b1, "R10", "external mode on CS fall with SCK low", ext_clk, 1);
    exp_f = {2'b00, res_sign, res_data};
    xfer(16'hA611, FRAME_W, got);
    check(got == exp_f, "R4", "frame after mode restore", got, exp_f);
    check(cfg == 8'h11, "R9", "cfg after restore frame", cfg, 8'h11);
    csb = 1'b1;
    tick(2 * HALF);
    check(sdo_oe == 1'b0, "R1", "oe with CS high", sdo_oe, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule